// File: doc/BRIEF.md
# Double-Buffered 10-bit PWM Generator

This block drives one pulse-width modulated output. An 8-bit period counter advances once every four input clocks multiplied by a selectable prescale ratio of 1, 4 or 16. Two sub-step bits extend the counter to a 10-bit time base. At 1:1 those bits are a clock-phase count. At the other ratios they are the upper two bits of the prescale count that is in use.

When the counter has reached the programmed period value and its next step is due, a new period begins. The counter returns to zero. The pending 10-bit duty value is copied into an active buffer, and the output goes high unless that value is zero. The output falls when the time base reaches the active duty value.

Software may rewrite the pending duty (an 8-bit high part and a 2-bit low part) at any moment. The change appears only in the following period, so a pulse is never cut short or stretched. The counter and the active buffer can be read back on dedicated outputs.

Top module: `pwm10_dbuf`

## Requirements
- R1: While enabled, consecutive rising edges of `pwm_out` are 4 × (`period`+1) × N clocks apart, where N is the prescale ratio.
- R2: `pre_sel` encodes the prescale ratio N as 0 → 1, 1 → 4, and 2 or 3 → 16.
- R3: For a duty value D = {`duty_hi`,`duty_lo`} with 0 < D < 4 × (`period`+1), `pwm_out` stays high for exactly D × N clocks per period.
- R4: When the duty value is 0, `pwm_out` stays low for the whole period.
- R5: When D ≥ 4 × (`period`+1), the falling edge never happens and `pwm_out` stays high continuously.
- R6: A write to the duty inputs in the middle of a period does not change that period's pulse, and it governs the next period. `duty_active` changes only when a new period starts.
- R7: `tmr_val` counts from 0 to `period` and steps once every 4 × N clocks. It never exceeds `period` while `period` is held.
- R8: In reset, or while `en` is low, `tmr_val` is 0 and `pwm_out` is low. `duty_active` equals the pending duty one clock later.
- R9: After `en` rises, `pwm_out` stays low until the first period boundary. That boundary comes 4 × (`period`+1) × N clocks after the first enabled clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock; one clock is one quarter of a counter step at 1:1 |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | PWM run enable |
| period | input | 8 | Last counter value of a period |
| duty_hi | input | 8 | Upper 8 bits of the pending duty |
| duty_lo | input | 2 | Lower 2 bits of the pending duty |
| pre_sel | input | 2 | Prescale ratio select (see R2) |
| pwm_out | output | 1 | PWM output |
| tmr_val | output | 8 | Current period counter value |
| duty_active | output | 10 | Duty value governing the current period |

## Verification
Every output is registered, so a change on an input shows up on the next rising edge. The bench drives inputs just after a falling edge and reads outputs at falling edges. An output that a stimulus changes is therefore read one falling edge after the edge that applied it. This fixes when the results fall due:
- A disable shows on the next edge.
- The first rising edge comes 4 × (`period`+1) × N falling-edge samples after the enable.
- The high time and period lengths are counts of falling-edge samples, running from one observed rising edge to the next.

A mid-period duty write is applied about twenty samples into a pulse. That pulse's length and `duty_active` are then checked before the next boundary is reached.

// File: rtl/pwm10_pkg.sv
package pwm10_pkg;
   typedef enum logic [1:0] {
      PS_DIV1  = 2'd0,
      PS_DIV4  = 2'd1,
      PS_DIV16 = 2'd2,
      PS_DIV16X = 2'd3
   } ps_sel_e;

   // log2 of the prescale ratio for a select code
   function automatic int unsigned ps_shift(input logic [1:0] sel);
      case (sel)
         2'd0:    ps_shift = 0;
         2'd1:    ps_shift = 2;
         default: ps_shift = 4;
      endcase
   endfunction
endpackage

// File: rtl/pwm10_prescaler.sv
module pwm10_prescaler #(
   parameter int FRAC_W  = 2,
   parameter int PS_LOG  = 4,
   localparam int SUB_W  = FRAC_W + PS_LOG
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [1:0]        sel,
   output logic              step,
   output logic [FRAC_W-1:0] nxt_frac
);
   import pwm10_pkg::*;

   logic [SUB_W-1:0] sub_q, sub_d, last;

   always_comb begin
      last  = SUB_W'((1 << (FRAC_W + ps_shift(sel))) - 1);
      step  = (sub_q >= last);
      sub_d = step ? '0 : sub_q + 1'b1;
   end

   // fractional bits taken from the prescale count at the selected weight
   always_comb begin
      nxt_frac = FRAC_W'(sub_d >> ps_shift(sel));
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !en) sub_q <= '0;
      else               sub_q <= sub_d;
   end
endmodule

// File: rtl/pwm10_timer.sv
module pwm10_timer #(
   parameter int TMR_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             step,
   input  logic [TMR_W-1:0] period,
   output logic [TMR_W-1:0] tmr_q,
   output logic [TMR_W-1:0] tmr_d,
   output logic             wrap
);
   always_comb begin
      wrap  = step && (tmr_q >= period);
      if (wrap)      tmr_d = '0;
      else if (step) tmr_d = tmr_q + 1'b1;
      else           tmr_d = tmr_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !en) tmr_q <= '0;
      else               tmr_q <= tmr_d;
   end
endmodule

// File: rtl/pwm10_outstage.sv
module pwm10_outstage #(
   parameter int DUTY_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              wrap,
   input  logic [DUTY_W-1:0] nxt_tb,
   input  logic [DUTY_W-1:0] pend,
   output logic              pwm_q,
   output logic [DUTY_W-1:0] active_q
);
   always_ff @(posedge clk) begin
      if (!rst_n || !en) begin
         pwm_q    <= 1'b0;
         active_q <= pend;
      end else if (wrap) begin
         active_q <= pend;
         pwm_q    <= (pend != '0);
      end else if (nxt_tb == active_q) begin
         pwm_q    <= 1'b0;
      end
   end
endmodule

// File: rtl/pwm10_dbuf.sv
module pwm10_dbuf #(
   parameter int TMR_W  = 8,
   parameter int FRAC_W = 2,
   parameter int PS_LOG = 4,
   localparam int DUTY_W = TMR_W + FRAC_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [TMR_W-1:0]  period,
   input  logic [TMR_W-1:0]  duty_hi,
   input  logic [FRAC_W-1:0] duty_lo,
   input  logic [1:0]        pre_sel,
   output logic              pwm_out,
   output logic [TMR_W-1:0]  tmr_val,
   output logic [DUTY_W-1:0] duty_active
);
   generate
      if (TMR_W < 2)  begin : g_bad_tmr  $error("TMR_W must be at least 2");  end
      if (FRAC_W < 1) begin : g_bad_frac $error("FRAC_W must be at least 1"); end
      if (PS_LOG != 4) begin : g_bad_ps  $error("PS_LOG must be 4 for ratios 1/4/16"); end
   endgenerate

   logic              step, wrap;
   logic [FRAC_W-1:0] nxt_frac;
   logic [TMR_W-1:0]  tmr_d;

   pwm10_prescaler #(.FRAC_W(FRAC_W), .PS_LOG(PS_LOG)) u_pre (
      .clk(clk), .rst_n(rst_n), .en(en), .sel(pre_sel),
      .step(step), .nxt_frac(nxt_frac)
   );

   pwm10_timer #(.TMR_W(TMR_W)) u_tmr (
      .clk(clk), .rst_n(rst_n), .en(en), .step(step), .period(period),
      .tmr_q(tmr_val), .tmr_d(tmr_d), .wrap(wrap)
   );

   pwm10_outstage #(.DUTY_W(DUTY_W)) u_out (
      .clk(clk), .rst_n(rst_n), .en(en), .wrap(wrap),
      .nxt_tb({tmr_d, nxt_frac}), .pend({duty_hi, duty_lo}),
      .pwm_q(pwm_out), .active_q(duty_active)
   );
endmodule

// File: rtl/pwm10_dbuf_chk.sv
module pwm10_dbuf_chk #(
   parameter int TMR_W  = 8,
   parameter int DUTY_W = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              en,
   input logic [TMR_W-1:0]  period,
   input logic              pwm_out,
   input logic [TMR_W-1:0]  tmr_val,
   input logic [DUTY_W-1:0] duty_active
);
   assert_off_when_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!pwm_out && tmr_val == '0));

   assert_tmr_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (en && tmr_val <= period && $stable(period)) |=> (tmr_val <= period));

   assert_active_at_boundary_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(en) && en && !$stable(duty_active)) |-> (tmr_val == '0));

   assert_rise_at_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwm_out) |-> (tmr_val == '0 && duty_active != '0));

   assert_zero_duty_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (duty_active == '0) |-> !pwm_out);
endmodule

bind pwm10_dbuf pwm10_dbuf_chk #(.TMR_W(TMR_W), .DUTY_W(DUTY_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .en(en), .period(period), .pwm_out(pwm_out),
   .tmr_val(tmr_val), .duty_active(duty_active)
);

// File: tb/pwm10_dbuf_test.sv
module pwm10_dbuf_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b0;
   logic [7:0] period = 8'h17;
   logic [7:0] duty_hi = 8'h12;
   logic [1:0] duty_lo = 2'd1;
   logic [1:0] pre_sel = 2'd0;
   logic       pwm_out;
   logic [7:0] tmr_val;
   logic [9:0] duty_active;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #4 clk = ~clk;

   pwm10_dbuf uut (
      .clk(clk), .rst_n(rst_n), .en(en), .period(period),
      .duty_hi(duty_hi), .duty_lo(duty_lo), .pre_sel(pre_sel),
      .pwm_out(pwm_out), .tmr_val(tmr_val), .duty_active(duty_active)
   );

   typedef struct packed {
      logic [7:0] pr;
      logic [1:0] ps;
      logic [9:0] duty;
      int         hi;
      int         per;
   } vec_t;

   localparam vec_t VECS [7] = '{
      '{8'hFF, 2'd0, 10'd512,  512,  1024},
      '{8'h3F, 2'd0, 10'd100,  100,  256},
      '{8'h17, 2'd0, 10'd50,   50,   96},
      '{8'h17, 2'd1, 10'd10,   40,   384},
      '{8'h3F, 2'd2, 10'd3,    48,   4096},
      '{8'h17, 2'd3, 10'd1,    16,   1536},
      '{8'hFF, 2'd1, 10'd1023, 4092, 4096}
   };

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic setup(input logic [7:0] pr, input logic [1:0] ps, input logic [9:0] d);
      @(negedge clk);
      en = 1'b0;
      @(negedge clk);
      period = pr; pre_sel = ps; duty_hi = d[9:2]; duty_lo = d[1:0];
      @(negedge clk);
   endtask

   task automatic wait_rise(output int waited);
      waited = 0;
      while (waited < 20000) begin
         @(negedge clk);
         waited++;
         if (pwm_out) break;
      end
   endtask

   // called right after a sample showing the rise; counts to the next rise
   task automatic measure(output int hi, output int per);
      logic prev = 1'b1;
      hi = 1; per = 1;
      while (per < 20000) begin
         @(negedge clk);
         if (pwm_out && !prev) break;
         per++;
         if (pwm_out) hi++;
         prev = pwm_out;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      int w, hi, per, tmax;
      // reset state (R8)
      repeat (3) @(negedge clk);
      check(pwm_out == 1'b0, "R8 reset output", pwm_out, 0);
      check(tmr_val == 8'd0, "R8 reset timer", tmr_val, 0);
      check(duty_active == 10'h049, "R8 reset active duty", duty_active, 10'h049);
      rst_n = 1'b1;

      // vector table: R1, R2, R3, R5 (last row is near full)
      foreach (VECS[i]) begin
         setup(VECS[i].pr, VECS[i].ps, VECS[i].duty);
         en = 1'b1;
         wait_rise(w);
         measure(hi, per);
         check(hi == VECS[i].hi, "R3 high time", hi, VECS[i].hi);
         check(per == VECS[i].per, "R1 R2 period", per, VECS[i].per);
      end

      // R9: first rise after enable
      setup(8'h17, 2'd0, 10'd20);
      en = 1'b1;
      wait_rise(w);
      check(w == 96, "R9 first rise delay", w, 96);

      // R6: mid-period duty write
      setup(8'h3F, 2'd0, 10'd100);
      en = 1'b1;
      wait_rise(w);
      hi = 1;
      repeat (20) begin
         @(negedge clk);
         if (pwm_out) hi++;
      end
      duty_hi = 8'd50; duty_lo = 2'd0;
      while (pwm_out) begin
         @(negedge clk);
         if (pwm_out) hi++;
      end
      check(hi == 100, "R6 current pulse unchanged", hi, 100);
      check(duty_active == 10'd100, "R6 active held mid-period", duty_active, 100);
      wait_rise(w);
      check(duty_active == 10'd200, "R6 active loaded at boundary", duty_active, 200);
      measure(hi, per);
      check(hi == 200, "R6 next pulse uses new duty", hi, 200);

      // R4: zero duty keeps output low
      setup(8'h17, 2'd0, 10'd0);
      en = 1'b1;
      hi = 0;
      repeat (400) begin
         @(negedge clk);
         if (pwm_out) hi++;
      end
      check(hi == 0, "R4 zero duty high samples", hi, 0);

      // R5: duty beyond period stays high
      setup(8'h17, 2'd0, 10'd1023);
      en = 1'b1;
      wait_rise(w);
      hi = 0;
      repeat (300) begin
         @(negedge clk);
         if (!pwm_out) hi++;
      end
      check(hi == 0, "R5 oversize duty low samples", hi, 0);

      // R7: timer readback and bound
      setup(8'h17, 2'd1, 10'd5);
      en = 1'b1;
      repeat (88) @(negedge clk);
      check(tmr_val == 8'd5, "R7 timer step rate", tmr_val, 5);
      tmax = 0;
      repeat (800) begin
         @(negedge clk);
         if (int'(tmr_val) > tmax) tmax = int'(tmr_val);
      end
      check(tmax == 8'h17, "R7 timer peak", tmax, 8'h17);

      // R8: disable clears, active follows pending
      duty_hi = 8'h33; duty_lo = 2'd2;
      en = 1'b0;
      @(negedge clk);
      check(pwm_out == 1'b0 && tmr_val == 8'd0, "R8 disable clears", tmr_val, 0);
      check(duty_active == 10'h0CE, "R8 disable active follows pending", duty_active, 10'h0CE);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule